// File: doc/BRIEF.md
# PWM Timer Prescaler and Control Register

This block makes the count-enable strobe for a motor PWM period counter and holds the 8-bit control register that sets it up. A divider running on the bus clock gives one strobe every 1, 2, 4 or 8 cycles. The strobe advances a free-running period counter. When that counter wraps from its all-ones value back to zero, the block marks a period boundary, loads the division ratio that software last wrote, and sets a sticky overflow flag. The flag drives the interrupt request directly.

Software reaches the register over a simple synchronous bus: a write enable, write data, and read data that is always valid. Writing a new ratio never disturbs the period in progress. The ratio is held as pending and becomes active only at the next wrap. The overflow flag is cleared by writing one to it. The register also holds a dither-enable bit that is driven to an output for the PWM engine to use.

Top module: `pwm_tick_top`

## Requirements
- R1: The active select code picks the strobe interval: 00 gives a strobe every cycle, 01 every 2nd cycle, 10 every 4th cycle and 11 every 8th cycle.
- R2: `periodCount` increases by one on each clock edge where `countStrobe` is high and holds otherwise. It wraps from all ones to zero. `periodWrap` is high in exactly the cycle where the strobe meets an all-ones count.
- R3: A written select code does not change the strobe rate until the next wrap. At that wrap it becomes active and the divider restarts, so the first strobe after the wrap comes a full new interval later.
- R4: The overflow flag is set on the clock edge that ends a `periodWrap` cycle, and `irqReq` equals the flag.
- R5: Writing 1 to the flag bit (`wrData[0]`) clears the flag. Writing 0 to it leaves the flag unchanged.
- R6: Read data lays out the fields as follows: `rdData[6:5]` is the pending select code, `rdData[2]` is dither enable, `rdData[0]` is the flag, and bits 7, 4, 3 and 1 always read 0.
- R7: After reset, every register field, the period count, the divider and the active select code are 0.
- R8: Dither enable is written from `wrData[2]`, reads back, and drives `ditherOn`.
- R9: When a wrap and a write of 1 to the flag bit fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| ditherOn | output | 1 | Dither enable to the PWM engine |
| irqReq | output | 1 | Overflow interrupt request |
| countStrobe | output | 1 | Count enable for the period counter |
| periodCount | output | CNT_W | Period counter value |
| periodWrap | output | 1 | Period boundary / overflow event |

## Verification
The bench builds the block with a 4-bit period counter. This makes one full period at most 128 cycles, so every select code can be swept across whole periods. The strobe pattern and the count are checked at every cycle against values computed from the cycle index and the interval. The short period also brings within reach a write issued just before a wrap (the deferred load), a clear issued in mid-period, and a clear issued in the exact cycle of a wrap.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 2;
  localparam int SEL_LSB  = 5;
  localparam int DITH_BIT = 2;
  localparam int FLAG_BIT = 0;
  localparam int DIV_W    = (1 << SEL_W) - 1;

  // control -> datapath
  typedef struct packed {
    logic [SEL_W-1:0] activeSel;
  } tickCmd_t;

  // datapath -> control
  typedef struct packed {
    logic wrap;
  } tickEvt_t;
endpackage

// File: rtl/pwm_tick_dp.sv
module pwm_tick_dp
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickCmd_t         cmd,
  output tickEvt_t         evt,
  output logic             countStrobe,
  output logic [CNT_W-1:0] periodCount
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMax;
  logic [CNT_W-1:0] periodCnt;

  // Terminal count of the divider for the active ratio
  always_comb begin
    divMax = DIV_W'((1 << cmd.activeSel) - 1);
  end

  assign countStrobe = (divCnt == divMax);
  assign evt.wrap    = countStrobe && (&periodCnt);
  assign periodCount = periodCnt;

  // The divider restarts on every strobe, which includes every wrap,
  // so a newly loaded ratio always begins from zero.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      periodCnt <= '0;
    end else begin
      if (countStrobe) divCnt <= '0;
      else             divCnt <= divCnt + DIV_W'(1);
      if (countStrobe) periodCnt <= periodCnt + CNT_W'(1);
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divMax); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !countStrobe |=> $stable(periodCount)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    countStrobe |=> (periodCount == CNT_W'($past(periodCount) + 1))); // R2
endmodule

// File: rtl/pwm_tick_ctrl.sv
module pwm_tick_ctrl
  import pwm_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  tickEvt_t         evt,
  output tickCmd_t         cmd,
  output logic [REG_W-1:0] rdData,
  output logic             ditherOn,
  output logic             irqReq
);
  logic [SEL_W-1:0] pendSel;
  logic [SEL_W-1:0] activeSel;
  logic             dithBit;
  logic             ovfFlag;
  logic             unusedWrBits;

  assign unusedWrBits = ^{wrData[REG_W-1:SEL_LSB+SEL_W],
                          wrData[SEL_LSB-1:DITH_BIT+1],
                          wrData[DITH_BIT-1:FLAG_BIT+1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel   <= '0;
      activeSel <= '0;
      dithBit   <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (wrEn) begin
        pendSel <= wrData[SEL_LSB +: SEL_W];
        dithBit <= wrData[DITH_BIT];
      end
      // The ratio is loaded only at a period boundary
      if (evt.wrap) activeSel <= pendSel;
      // If a set and a clear arrive together, the set takes priority
      if (evt.wrap)                       ovfFlag <= 1'b1;
      else if (wrEn && wrData[FLAG_BIT])  ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData                     = '0;
    rdData[SEL_LSB +: SEL_W]   = pendSel;
    rdData[DITH_BIT]           = dithBit;
    rdData[FLAG_BIT]           = ovfFlag;
  end

  assign cmd.activeSel = activeSel;
  assign ditherOn      = dithBit;
  assign irqReq        = ovfFlag;

  AST_SEL_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    !evt.wrap |=> $stable(cmd.activeSel)); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrap |=> irqReq); // R4
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[FLAG_BIT] && !evt.wrap) |=> !irqReq); // R5
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !(wrEn && wrData[FLAG_BIT])) |=> irqReq); // R5
endmodule

// File: rtl/pwm_tick_top.sv
module pwm_tick_top
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             ditherOn,
  output logic             irqReq,
  output logic             countStrobe,
  output logic [CNT_W-1:0] periodCount,
  output logic             periodWrap
);
  tickCmd_t cmd;
  tickEvt_t evt;

  pwm_tick_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .evt      (evt),
    .cmd      (cmd),
    .rdData   (rdData),
    .ditherOn (ditherOn),
    .irqReq   (irqReq)
  );

  pwm_tick_dp #(.CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .evt         (evt),
    .countStrobe (countStrobe),
    .periodCount (periodCount)
  );

  assign periodWrap = evt.wrap;
endmodule

// File: tb/sim_pwm_tick_top.sv
`timescale 1ns/100ps
module sim_pwm_tick_top;
  localparam int CW  = 4;
  localparam int LEN = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [7:0]    wrData;
  logic [7:0]    rdData;
  logic          ditherOn, irqReq, countStrobe, periodWrap;
  logic [CW-1:0] periodCount;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_tick_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ditherOn(ditherOn), .irqReq(irqReq), .countStrobe(countStrobe),
    .periodCount(periodCount), .periodWrap(periodWrap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic waitWrap();
    int n = 0;
    while (!periodWrap && n < 400) begin step(); n++; end
    chk("R2 wrap reached", periodWrap, 1);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sels[4] = '{3, 0, 1, 2};
    rstN = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    repeat (3) step();
    rstN = 1'b1;
    // R7 reset state
    chk("R7 rdData", rdData, 8'h00);
    chk("R7 irqReq", irqReq, 0);
    chk("R7 count", periodCount, 0);
    chk("R7 ditherOn", ditherOn, 0);
    chk("R7 strobe at divide-by-1", countStrobe, 1);

    // R1/R2 divide-by-1 from reset
    for (int i = 1; i <= 20; i++) begin
      step();
      chk("R2 count div1", periodCount, i % LEN);
      chk("R1 strobe div1", countStrobe, 1);
      chk("R2 wrap div1", periodWrap, (i % LEN) == LEN - 1);
    end
    chk("R4 flag after wrap", rdData[0], 1);
    chk("R4 irqReq", irqReq, 1);

    // R5 writing 0 keeps, writing 1 clears
    wr(8'h00);
    chk("R5 write0 keeps flag", irqReq, 1);
    wr(8'h01);
    chk("R5 write1 clears flag", rdData[0], 0);
    chk("R5 irq cleared", irqReq, 0);

    // R6/R8 field layout and dither
    wr(8'hFF);
    chk("R6 readback all ones", rdData, 8'h64);
    chk("R8 ditherOn set", ditherOn, 1);
    wr(8'h04);
    chk("R6 dither only", rdData, 8'h04);
    wr(8'h9A);
    chk("R6 reserved ignored", rdData, 8'h00);
    chk("R8 ditherOn cleared", ditherOn, 0);

    // Sweep each ratio over whole periods
    foreach (sels[k]) begin
      int d = 1 << sels[k];
      logic [7:0] sb = 8'(sels[k] << 5);
      wr(sb);
      chk("R6 pending sel readback", rdData, {1'b0, sb[6:5], 5'b0} | {7'b0, irqReq});
      if (k == 0) begin
        // R3 old ratio (div1) still active until the wrap
        while (!periodWrap) begin
          chk("R3 deferred ratio", countStrobe, 1);
          step();
        end
      end
      waitWrap();
      step();
      for (int i = 1; i <= LEN * d; i++) begin
        chk("R1 strobe pattern", countStrobe, (i % d) == 0);
        chk("R3 count after load", periodCount, (i - 1) / d);
        chk("R2 wrap position", periodWrap, i == LEN * d);
        if (i == 4 * d + 1) chk("R5 mid-period clear", irqReq, 0);
        if (i == 4 * d || i == LEN * d) wr(sb | 8'h01);
        else if (i < LEN * d) step();
      end
      // R9 clear issued in the wrap cycle loses to the set
      chk("R9 set wins", rdData[0], 1);
      chk("R4 irq after wrap", irqReq, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule